// File: doc/BRIEF.md
# Supervisor Domain Protection Root Register

This block is a machine-level control register that sets up physical-address protection for supervisor domains. It holds three fields:

- a mode selector, which picks the protection scheme;
- a supervisor domain identifier;
- the page number of the root protection table.

The current field values go straight to a downstream table-walk unit.

The register accepts CSR read and write requests together with the requester's privilege level. A request from below machine privilege is refused with an illegal-access flag. A machine-level write is legalised field by field under write-any-read-legal rules. An unsupported mode encoding keeps the previous mode. With the bare mode in effect, the identifier and page number must be zero. In the table modes, the two lowest page-number bits are tied to zero. Only a parameterised number of identifier bits is implemented, and software finds that number by writing all ones and reading back.

A bare-mode write with nonzero fields raises a fault and leaves the register untouched. A one-cycle change pulse tells a downstream permission cache to flush when the mode or identifier changes.

Top module: `prot_root_csr`

## Requirements
- R1: After reset the register reads mode 0 (bare), identifier 0 and page number 0, and every flag output is low.
- R2: A request (read or write) with `priv_i` other than 2'b11 (machine) sets `illegal_o` and changes no field. `illegal_o` is high for exactly the cycle after the request.
- R3: A machine write whose resulting mode is bare, with a nonzero written identifier or page number, sets `fault_o` for the cycle after the write and leaves all fields unchanged.
- R4: A machine write whose resulting mode is bare, with a zero identifier and a zero page number, stores bare mode with both fields zero, and raises no fault.
- R5: In the 32-bit build the mode encodings are 0 = bare, 1 = 34-bit allow/deny, and 2 = 34-bit read/write permission. Encoding 3 is unsupported. A write carrying it keeps the old mode, and the other fields are still legalised against that old mode.
- R6: Whenever the mode is not bare, page-number bits [1:0] read as zero, whatever value was written.
- R7: Only the low `SDID_LEN` identifier bits (default 5) can be set, and the upper bits read as zero. Writing all ones to the identifier reads back 2^SDID_LEN-1.
- R8: `cfg_changed_o` is high for exactly the cycle after an accepted write that changed the mode or the identifier, and is low otherwise.
- R9: In the 32-bit build, `csr_rdata_o` holds mode in [31:30], identifier in [29:22] and page number in [21:0]. `mode_o`, `sdid_o` and `ppn_o` carry the same stored values.
- R10: A machine read (`csr_we_i`=0) changes no field and raises no flag. Fields update at the clock edge that takes the write, and the flags are registered, one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_req_i | input | 1 | Access request, one per cycle |
| csr_we_i | input | 1 | 1 = write, 0 = read |
| csr_wdata_i | input | XLEN | Write data |
| priv_i | input | 2 | Requester privilege, 2'b11 = machine |
| csr_rdata_o | output | XLEN | Current register value |
| illegal_o | output | 1 | Access from below machine privilege |
| fault_o | output | 1 | Bare-mode write with nonzero fields |
| cfg_changed_o | output | 1 | Mode or identifier changed, flush request |
| mode_o | output | MODE_W | Current mode to table walker |
| sdid_o | output | SDID_W | Current identifier |
| ppn_o | output | PPN_W | Current root page number |

## Verification
The bench sweeps every privilege level and every mode encoding against identifier and page patterns that are zero, all ones, have only low bits set, or are mixed. Because register state carries from write to write, each case is reached from many starting modes.

It targets the unsupported encoding reached from a bare mode. A design that stored that encoding, or left bare without checking the fields, would read back a nonzero page number under bare mode or report a wrong fault. Identifier all-ones writes expose a design that keeps unimplemented bits. Page numbers with the low bits set catch a missing tie-off.

Repeated identical writes show whether the change pulse fires when nothing changed. Lower-privilege writes show whether the register leaks a write past the illegal flag.

// File: rtl/prot_root_pkg.sv
package prot_root_pkg;
  localparam logic [1:0] PRIV_M = 2'b11;
  localparam int unsigned MODE_BARE = 0;

  function automatic int unsigned mode_w(input int unsigned xlen);
    return (xlen == 32) ? 2 : 4;
  endfunction

  function automatic int unsigned sdid_w(input int unsigned xlen);
    return (xlen == 32) ? 8 : 16;
  endfunction
endpackage

// File: rtl/prot_root_legalize.sv
module prot_root_legalize
  import prot_root_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned SDID_LEN  = 5,
  parameter logic [15:0] MODE_MASK = 16'h0007,
  localparam int unsigned MODE_W   = mode_w(XLEN),
  localparam int unsigned SDID_W   = sdid_w(XLEN),
  localparam int unsigned PPN_W    = XLEN - MODE_W - SDID_W
) (
  input  logic [MODE_W-1:0] cur_mode_i,
  input  logic [XLEN-1:0]   wdata_i,
  output logic [MODE_W-1:0] nxt_mode_o,
  output logic [SDID_W-1:0] nxt_sdid_o,
  output logic [PPN_W-1:0]  nxt_ppn_o,
  output logic              bad_o
);
  localparam logic [SDID_W-1:0] SDID_MASK = SDID_W'((64'd1 << SDID_LEN) - 64'd1);

  logic [MODE_W-1:0] w_mode;
  logic [SDID_W-1:0] w_sdid;
  logic [PPN_W-1:0]  w_ppn;
  logic              w_sup;

  assign w_mode = wdata_i[XLEN-1 -: MODE_W];
  assign w_sdid = wdata_i[PPN_W +: SDID_W];
  assign w_ppn  = wdata_i[PPN_W-1:0];
  // bare is always legal
  assign w_sup  = (w_mode == MODE_W'(MODE_BARE)) || MODE_MASK[w_mode];

  always_comb begin
    nxt_mode_o = w_sup ? w_mode : cur_mode_i;
    bad_o      = 1'b0;
    if (nxt_mode_o == MODE_W'(MODE_BARE)) begin
      nxt_sdid_o = '0;
      nxt_ppn_o  = '0;
      bad_o      = (w_sdid != '0) || (w_ppn != '0);
    end else begin
      nxt_sdid_o = w_sdid & SDID_MASK;
      nxt_ppn_o  = {w_ppn[PPN_W-1:2], 2'b00};
    end
  end
endmodule

// File: rtl/prot_root_regs.sv
module prot_root_regs
  import prot_root_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned SDID_LEN  = 5,
  parameter logic [15:0] MODE_MASK = 16'h0007,
  localparam int unsigned MODE_W   = mode_w(XLEN),
  localparam int unsigned SDID_W   = sdid_w(XLEN),
  localparam int unsigned PPN_W    = XLEN - MODE_W - SDID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              apply_i,
  input  logic              illegal_req_i,
  input  logic              fault_req_i,
  input  logic [MODE_W-1:0] nxt_mode_i,
  input  logic [SDID_W-1:0] nxt_sdid_i,
  input  logic [PPN_W-1:0]  nxt_ppn_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [SDID_W-1:0] sdid_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic              illegal_o,
  output logic              fault_o,
  output logic              cfg_changed_o
);
  localparam logic [SDID_W-1:0] SDID_MASK = SDID_W'((64'd1 << SDID_LEN) - 64'd1);

  logic changed;
  assign changed = apply_i && ((nxt_mode_i != mode_o) || (nxt_sdid_i != sdid_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o        <= MODE_W'(MODE_BARE);
      sdid_o        <= '0;
      ppn_o         <= '0;
      illegal_o     <= 1'b0;
      fault_o       <= 1'b0;
      cfg_changed_o <= 1'b0;
    end else begin
      if (apply_i) begin
        mode_o <= nxt_mode_i;
        sdid_o <= nxt_sdid_i;
        ppn_o  <= nxt_ppn_i;
      end
      illegal_o     <= illegal_req_i;
      fault_o       <= fault_req_i;
      cfg_changed_o <= changed;
    end
  end

  // R4
  bare_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_W'(MODE_BARE)) |-> (sdid_o == '0 && ppn_o == '0));
  // R6
  ppn_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != MODE_W'(MODE_BARE)) |-> (ppn_o[1:0] == 2'b00));
  // R7
  sdid_impl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdid_o & ~SDID_MASK) == '0);
  // R5
  mode_sup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_W'(MODE_BARE)) || MODE_MASK[mode_o]);
  // R8
  cfg_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_changed_o |-> (mode_o != $past(mode_o) || sdid_o != $past(sdid_o)));
endmodule

// File: rtl/prot_root_csr.sv
module prot_root_csr
  import prot_root_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned SDID_LEN  = 5,
  parameter logic [15:0] MODE_MASK = 16'h0007,
  localparam int unsigned MODE_W   = mode_w(XLEN),
  localparam int unsigned SDID_W   = sdid_w(XLEN),
  localparam int unsigned PPN_W    = XLEN - MODE_W - SDID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_req_i,
  input  logic              csr_we_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  input  logic [1:0]        priv_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              illegal_o,
  output logic              fault_o,
  output logic              cfg_changed_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [SDID_W-1:0] sdid_o,
  output logic [PPN_W-1:0]  ppn_o
);
  logic              m_req, wr, bad, apply;
  logic [MODE_W-1:0] nxt_mode;
  logic [SDID_W-1:0] nxt_sdid;
  logic [PPN_W-1:0]  nxt_ppn;

  assign m_req = csr_req_i && (priv_i == PRIV_M);
  assign wr    = m_req && csr_we_i;
  assign apply = wr && !bad;

  prot_root_legalize #(.XLEN(XLEN), .SDID_LEN(SDID_LEN), .MODE_MASK(MODE_MASK)) u_legal (
    .cur_mode_i (mode_o),
    .wdata_i    (csr_wdata_i),
    .nxt_mode_o (nxt_mode),
    .nxt_sdid_o (nxt_sdid),
    .nxt_ppn_o  (nxt_ppn),
    .bad_o      (bad)
  );

  prot_root_regs #(.XLEN(XLEN), .SDID_LEN(SDID_LEN), .MODE_MASK(MODE_MASK)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .apply_i       (apply),
    .illegal_req_i (csr_req_i && !m_req),
    .fault_req_i   (wr && bad),
    .nxt_mode_i    (nxt_mode),
    .nxt_sdid_i    (nxt_sdid),
    .nxt_ppn_i     (nxt_ppn),
    .mode_o        (mode_o),
    .sdid_o        (sdid_o),
    .ppn_o         (ppn_o),
    .illegal_o     (illegal_o),
    .fault_o       (fault_o),
    .cfg_changed_o (cfg_changed_o)
  );

  assign csr_rdata_o = {mode_o, sdid_o, ppn_o};

  // R2
  illegal_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && priv_i != PRIV_M) |=> illegal_o);
  // R2
  illegal_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && priv_i != PRIV_M) |=> $stable(csr_rdata_o));
  // R3
  fault_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $stable(csr_rdata_o));
  // R10
  read_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && !csr_we_i) |=> ($stable(csr_rdata_o) && !fault_o && !cfg_changed_o));
endmodule

// File: tb/prot_root_csr_test.sv
module prot_root_csr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [31:0] wdata = '0;
  logic [1:0]  priv = 2'b11;
  logic [31:0] rdata;
  logic        illegal, fault, cfg;
  logic [1:0]  mode;
  logic [7:0]  sdid;
  logic [21:0] ppn;

  int checks = 0, fails = 0, cyc = 0;
  logic [1:0]  m_m = 0;
  logic [7:0]  m_s = 0;
  logic [21:0] m_p = 0;

  always #5 clk = ~clk;

  prot_root_csr uut (
    .clk_i(clk), .rst_ni(rst_n), .csr_req_i(req), .csr_we_i(we), .csr_wdata_i(wdata),
    .priv_i(priv), .csr_rdata_o(rdata), .illegal_o(illegal), .fault_o(fault),
    .cfg_changed_o(cfg), .mode_o(mode), .sdid_o(sdid), .ppn_o(ppn)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired act=%0d exp<=100000", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] pv, input logic w, input logic [31:0] d);
    logic e_ill, e_flt, e_cfg;
    logic [1:0] nm;
    logic [7:0] ns;
    logic [21:0] np;
    e_ill = (pv != 2'b11);
    e_flt = 0;
    e_cfg = 0;
    if (!e_ill && w) begin
      nm = (d[31:30] == 2'd3) ? m_m : d[31:30];   // R5
      if (nm == 0) begin
        if (d[29:22] != 0 || d[21:0] != 0) e_flt = 1; // R3
        else begin
          e_cfg = (m_m != 0) || (m_s != 0);          // R4
          m_m = 0; m_s = 0; m_p = 0;
        end
      end else begin
        ns = d[29:22] & 8'h1f;                     // R7
        np = {d[21:2], 2'b00};                     // R6
        e_cfg = (nm != m_m) || (ns != m_s);        // R8
        m_m = nm; m_s = ns; m_p = np;
      end
    end
    req = 1; we = w; priv = pv; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 0; we = 0;
    check("R9 rdata", rdata, {m_m, m_s, m_p});
    check("R9 fields", {mode, sdid, ppn}, {m_m, m_s, m_p});
    check("R2 illegal", {31'b0, illegal}, {31'b0, e_ill});
    check("R3 fault", {31'b0, fault}, {31'b0, e_flt});
    check("R8 cfg_changed", {31'b0, cfg}, {31'b0, e_cfg});
    @(posedge clk); @(negedge clk);
    // R10 flags last one cycle
    check("R10 flags cleared", {29'b0, illegal, fault, cfg}, 32'b0);
  endtask

  initial begin
    logic [7:0]  sp [5];
    logic [21:0] pp [5];
    sp = '{8'h00, 8'h01, 8'h1f, 8'hff, 8'ha5};
    pp = '{22'h0, 22'h1, 22'h3, 22'h3fffff, 22'h12345};
    repeat (3) @(negedge clk);
    check("R1 reset rdata", rdata, 32'h0);
    check("R1 reset flags", {29'b0, illegal, fault, cfg}, 32'b0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", rdata, 32'h0);
    // R7 identifier discovery
    access(2'b11, 1'b1, {2'd1, 8'hff, 22'h0});
    check("R7 sdid width", {24'b0, sdid}, 32'h1f);
    // R5 unsupported from non-bare keeps mode
    access(2'b11, 1'b1, {2'd3, 8'h02, 22'h7});
    // R4 back to bare
    access(2'b11, 1'b1, 32'h0);
    // R5 unsupported from bare with nonzero -> fault
    access(2'b11, 1'b1, {2'd3, 8'h00, 22'h4});
    // R8 repeated identical write: no pulse on second
    access(2'b11, 1'b1, {2'd2, 8'h03, 22'h10});
    access(2'b11, 1'b1, {2'd2, 8'h03, 22'h10});
    access(2'b11, 1'b1, {2'd2, 8'h03, 22'h20});
    for (int pv = 0; pv < 4; pv++)
      for (int md = 0; md < 4; md++)
        for (int si = 0; si < 5; si++)
          for (int pi = 0; pi < 5; pi++) begin
            access(pv[1:0], 1'b1, {md[1:0], sp[si], pp[pi]});
            if (pi == 2) access(pv[1:0], 1'b0, 32'hffffffff); // R10 read
          end
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule